// File: doc/BRIEF.md
# Caption Line Selector for the Vertical Blanking Interval

This block decides which video lines inside the vertical blanking interval are handed to a closed-caption data slicer. It receives the separated vertical and horizontal sync pulses and the fields of a caption position register. It emits a one-clock strobe for every line that must be sliced, and a second strobe for the line whose clock run-in burst sets the slice reference voltage. It also emits a flag that names the current field.

Both sync inputs pass through two-flop synchronizers. A falling vertical sync edge clears a line counter, and every rising horizontal sync edge after it advances that counter by one. Each field yields two sliced lines. One is the caption line, which sits at count 0x11. The other is a line chosen by a 5-bit register field. The reference-voltage strobe is limited to one field and to one line choice, both selected by separate controls.

A small state machine sequences the counter. `S_WAIT` holds after reset until the first vertical fall. `S_WAIT -> S_COUNT` happens on that fall. `S_COUNT -> S_DONE` happens on the horizontal pulse taken at count 0x1F. `S_COUNT -> S_COUNT` and `S_DONE -> S_COUNT` happen on every later vertical fall, which restarts the count.

Top module: `cc_line_picker`

## Requirements
- R1: After reset, `slice_stb`, `vref_stb` and `field_id` are all 0.
- R2: Before the first falling edge of `vsep_in` after reset, no horizontal pulse produces any strobe.
- R3: A falling edge of `vsep_in` clears the line count. The k-th rising edge of `hsep_in` after it (k counted from 0) is line count k. That line gives a `slice_stb` when k equals `cap_pos[4:0]`.
- R4: Line count 0x11 always gives a `slice_stb`, in every field. When `cap_pos[4:0]` is 0x11, that line gives exactly one strobe.
- R5: The line count saturates at 0x1F. Horizontal pulses after the one taken at count 0x1F produce no strobe until the next vertical fall, even when `cap_pos[4:0]` is 0x1F.
- R6: `cap_pos[7:6]` selects the reference line. 00 selects count 0x11, 01 selects count `cap_pos[4:0]`, 10 selects both, and 11 selects none.
- R7: `vref_stb` fires only in the field whose `field_id` equals `ref_field_sel` (0 = first field, 1 = second field).
- R8: On each falling edge of `vsep_in`, `field_id` is loaded with 1 if more than HALF_LINE/2 clocks have passed since the last horizontal pulse, and 0 otherwise. At no other time does it change.
- R9: Every strobe is exactly one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vsep_in | input | 1 | Separated vertical sync, asynchronous |
| hsep_in | input | 1 | Separated horizontal sync, asynchronous |
| cap_pos | input | 8 | [4:0] programmed line count, [7:6] reference-line mode |
| ref_field_sel | input | 1 | Field that generates the reference voltage |
| slice_stb | output | 1 | One-clock strobe per sliced line |
| vref_stb | output | 1 | One-clock strobe for the reference-voltage line |
| field_id | output | 1 | Field flag, 0 = first field, 1 = second field |

## Verification
Fields are driven with the vertical fall placed either just after a horizontal pulse or half a line after it. This separates the two field decisions and shows that the flag holds steady between falls. The programmed line is tried at 0x00, an ordinary mid value, 0x11 (which coincides with the caption line) and 0x1F (the saturation edge). Each field runs past count 0x1F to expose any strobe after saturation. All four reference-line modes are paired with matching and non-matching field selections. Horizontal pulses sent before the first vertical fall confirm that the counter stays idle.

// File: rtl/clg_pkg.sv
package clg_pkg;
    typedef enum logic [1:0] {
        S_WAIT  = 2'd0,
        S_COUNT = 2'd1,
        S_DONE  = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        VR_CAPTION = 2'b00,
        VR_PROG    = 2'b01,
        VR_BOTH    = 2'b10,
        VR_NONE    = 2'b11
    } vref_mode_t;
endpackage

// File: rtl/clg_sync.sv
module clg_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[i]   <= 1'b0;
                sync_out[i] <= 1'b0;
            end else begin
                meta_q[i]   <= async_in[i];
                sync_out[i] <= meta_q[i];
            end
        end
    end
endmodule

// File: rtl/clg_edge.sv
module clg_edge #(
    parameter int HALF_LINE = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vs_s,
    input  logic hs_s,
    output logic v_fall,
    output logic h_pulse,
    output logic late_phase
);
    localparam int EW     = $clog2(HALF_LINE + 1);
    localparam int THRESH = HALF_LINE / 2;

    logic          vs_d, hs_d;
    logic [EW-1:0] elapsed;

    assign v_fall     = vs_d & ~vs_s;
    assign h_pulse    = hs_s & ~hs_d;
    assign late_phase = (elapsed > EW'(THRESH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vs_d    <= 1'b0;
            hs_d    <= 1'b0;
            elapsed <= '0;
        end else begin
            vs_d <= vs_s;
            hs_d <= hs_s;
            if (h_pulse)
                elapsed <= '0;
            else if (elapsed < EW'(HALF_LINE))
                elapsed <= elapsed + 1'b1;
        end
    end

    AST_HPULSE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        h_pulse |=> !h_pulse); // R9
endmodule

// File: rtl/clg_match.sv
module clg_match #(
    parameter int CNT_W   = 5,
    parameter int CAP_CNT = 17
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] prog_line,
    output logic             hit_prog,
    output logic             hit_cap
);
    assign hit_prog = (cnt == prog_line);
    assign hit_cap  = (cnt == CNT_W'(CAP_CNT));
endmodule

// File: rtl/clg_seq.sv
module clg_seq
    import clg_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             v_fall,
    input  logic             h_pulse,
    input  logic             late_phase,
    input  logic             hit_prog,
    input  logic             hit_cap,
    input  logic [1:0]       vref_mode,
    input  logic             ref_field,
    output logic [CNT_W-1:0] cnt,
    output logic             slice_stb,
    output logic             vref_stb,
    output logic             field_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    seq_state_t state, state_nxt;
    logic       line_ev;
    logic       ref_hit;

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_WAIT:  if (v_fall) state_nxt = S_COUNT;
            S_COUNT: if (v_fall) state_nxt = S_COUNT;
                     else if (h_pulse && cnt == CNT_MAX) state_nxt = S_DONE;
            S_DONE:  if (v_fall) state_nxt = S_COUNT;
            default: state_nxt = S_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_WAIT;
            cnt     <= '0;
            field_q <= 1'b0;
        end else begin
            state <= state_nxt;
            if (v_fall) begin
                cnt     <= '0;
                field_q <= late_phase;
            end else if (state == S_COUNT && h_pulse && cnt != CNT_MAX) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign line_ev = (state == S_COUNT) && h_pulse && !v_fall;

    always_comb begin
        unique case (vref_mode_t'(vref_mode))
            VR_CAPTION: ref_hit = hit_cap;
            VR_PROG:    ref_hit = hit_prog;
            VR_BOTH:    ref_hit = hit_cap | hit_prog;
            VR_NONE:    ref_hit = 1'b0;
            default:    ref_hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slice_stb <= 1'b0;
            vref_stb  <= 1'b0;
        end else begin
            slice_stb <= line_ev && (hit_cap || hit_prog);
            vref_stb  <= line_ev && ref_hit && (field_q == ref_field);
        end
    end

    AST_SLICE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        slice_stb |=> !slice_stb); // R9
    AST_VREF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        vref_stb |=> !vref_stb); // R9
    AST_QUIET_BEFORE_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT) |=> !slice_stb && !vref_stb); // R2
    AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !v_fall |=> $stable(field_q)); // R8
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DONE) && !v_fall |=> (state == S_DONE) && (cnt == CNT_MAX)); // R5
    AST_VREF_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        vref_stb |-> $past(field_q) == $past(ref_field)); // R7
endmodule

// File: rtl/cc_line_picker.sv
module cc_line_picker #(
    parameter int HALF_LINE = 1024,
    parameter int CNT_W     = 5,
    parameter int CAP_CNT   = 17
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vsep_in,
    input  logic       hsep_in,
    input  logic [7:0] cap_pos,
    input  logic       ref_field_sel,
    output logic       slice_stb,
    output logic       vref_stb,
    output logic       field_id
);
    logic [1:0]       sync_q;
    logic             v_fall, h_pulse, late_phase;
    logic             hit_prog, hit_cap;
    logic [CNT_W-1:0] cnt;

    clg_sync #(.W(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({vsep_in, hsep_in}),
        .sync_out (sync_q)
    );

    clg_edge #(.HALF_LINE(HALF_LINE)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .vs_s       (sync_q[1]),
        .hs_s       (sync_q[0]),
        .v_fall     (v_fall),
        .h_pulse    (h_pulse),
        .late_phase (late_phase)
    );

    clg_match #(.CNT_W(CNT_W), .CAP_CNT(CAP_CNT)) u_match (
        .cnt       (cnt),
        .prog_line (cap_pos[CNT_W-1:0]),
        .hit_prog  (hit_prog),
        .hit_cap   (hit_cap)
    );

    clg_seq #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .v_fall     (v_fall),
        .h_pulse    (h_pulse),
        .late_phase (late_phase),
        .hit_prog   (hit_prog),
        .hit_cap    (hit_cap),
        .vref_mode  (cap_pos[7:6]),
        .ref_field  (ref_field_sel),
        .cnt        (cnt),
        .slice_stb  (slice_stb),
        .vref_stb   (vref_stb),
        .field_q    (field_id)
    );
endmodule

// File: tb/cc_line_picker_tb.sv
module cc_line_picker_tb;
    localparam int HL = 32;

    typedef struct {
        int line;
        bit slc;
        bit vrf;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vsep_in = 1'b1;
    logic       hsep_in = 1'b0;
    logic [7:0] cap_pos = 8'h00;
    logic       ref_field_sel = 1'b0;
    logic       slice_stb, vref_stb, field_id;

    int   n_run = 0;
    int   n_fail = 0;
    int   n_seen = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    bit m_active = 1'b0;
    int m_cnt = 0;
    bit m_field = 1'b0;
    bit prev_slc = 1'b0, prev_vrf = 1'b0;

    always #2.5 clk = ~clk;

    cc_line_picker #(.HALF_LINE(HL)) u_dut (
        .clk(clk), .rst_n(rst_n), .vsep_in(vsep_in), .hsep_in(hsep_in),
        .cap_pos(cap_pos), .ref_field_sel(ref_field_sel),
        .slice_stb(slice_stb), .vref_stb(vref_stb), .field_id(field_id)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: one horizontal pulse, with the scoreboard item pushed first.
    task automatic hs_pulse();
        exp_t it;
        bit   s, v, cap, prg, rh;
        if (m_active && m_cnt <= 31) begin
            cap = (m_cnt == 17);
            prg = (m_cnt == int'(cap_pos[4:0]));
            s   = cap || prg;
            case (cap_pos[7:6])
                2'b00:   rh = cap;
                2'b01:   rh = prg;
                2'b10:   rh = cap || prg;
                default: rh = 1'b0;
            endcase
            v = rh && (m_field == ref_field_sel);
            if (s || v) begin
                it.line = m_cnt; it.slc = s; it.vrf = v;
                sb_q.push_back(it);
            end
            m_cnt++;
        end
        @(negedge clk) hsep_in = 1'b1;
        repeat (3) @(negedge clk);
        hsep_in = 1'b0;
        repeat (37) @(negedge clk);
    endtask

    // Vertical fall placed early (first field) or late (second field) after a pulse.
    task automatic new_field(input bit late);
        @(negedge clk) hsep_in = 1'b1;
        repeat (3) @(negedge clk);
        hsep_in = 1'b0;
        if (m_active && m_cnt <= 31) m_cnt++;
        repeat (late ? 17 : 1) @(negedge clk);
        chk(field_id == m_field, "R8 flag held before fall", field_id, m_field);
        vsep_in = 1'b0;
        m_active = 1'b1; m_cnt = 0; m_field = late;
        repeat (6) @(negedge clk);
        chk(field_id == late, "R8 flag after fall", field_id, late);
        repeat (4) @(negedge clk);
        vsep_in = 1'b1;
        repeat (30) @(negedge clk);
    endtask

    task automatic run_field(input bit late, input logic [7:0] cp, input bit rf);
        cap_pos = cp; ref_field_sel = rf;
        new_field(late);
        for (int k = 0; k < 40; k++) hs_pulse();
        chk(sb_q.size() == 0, "R3 missing strobes at field end", sb_q.size(), 0);
    endtask

    // Monitor: pops the scoreboard on each observed strobe.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if ((slice_stb && prev_slc) || (vref_stb && prev_vrf))
                chk(1'b0, "R9 strobe wider than one clock", 2, 1);
            if (slice_stb || vref_stb) begin
                n_seen++;
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R2/R5 unexpected strobe", {slice_stb, vref_stb}, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(slice_stb == e.slc, $sformatf("R3/R4 slice line %0d", e.line), slice_stb, e.slc);
                    chk(vref_stb == e.vrf, $sformatf("R6/R7 vref line %0d", e.line), vref_stb, e.vrf);
                end
            end
            prev_slc = slice_stb;
            prev_vrf = vref_stb;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(slice_stb == 0 && vref_stb == 0, "R1 strobes in reset", {slice_stb, vref_stb}, 0);
        chk(field_id == 0, "R1 field in reset", field_id, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        cap_pos = 8'h11;
        for (int k = 0; k < 20; k++) hs_pulse();
        chk(n_seen == 0, "R2 strobes before first vertical fall", n_seen, 0);

        run_field(1'b0, 8'h05, 1'b0);  // R3 R4 R6 mode 00, field match
        run_field(1'b1, 8'h05, 1'b0);  // R7 field mismatch, R8 second field
        run_field(1'b1, 8'h91, 1'b1);  // R4 coinciding line, mode 10
        run_field(1'b0, 8'h5F, 1'b0);  // R5 line 0x1F and saturation, mode 01
        run_field(1'b0, 8'hC0, 1'b0);  // R6 mode 11, line 0
        run_field(1'b0, 8'h83, 1'b0);  // R6 mode 10 two reference lines
        run_field(1'b1, 8'h09, 1'b1);  // R6 mode 00 in second field
        chk(n_seen == 13, "R3 total strobe events", n_seen, 13);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule